// File: doc/BRIEF.md
# GPIO Port With Peripheral Override

This block is a five-pin general-purpose I/O port for an 8-bit register bus. Software programs a direction register (1 = pin is an input, 0 = pin is an output) and an output latch, and reads the pins back through a two-flop synchronizer. Attached peripherals can take over a pin through per-pin override requests. An override can force the pad to drive or to float, and it can also supply the driven value. These overrides act only on the pad controls. They never reach the stored registers, so software read-modify-write of the direction register stays safe while a peripheral owns a pin.

The top three bits of the port data register have no pin behind them. They are plain read/write control bits, and each one turns on the weak pull-ups of one neighbouring port. The bus is a plain synchronous interface with a 2-bit address, a write strobe and 8-bit data. Reads are combinational with zero wait states, and the block never stalls a transfer, so there is no back-pressure. Address map: 0 = port data, 1 = output latch, 2 = direction, 3 = unused.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the direction register reads 0x1F, the latch reads 0x00, port-data bits 7:5 read 0, `pu_en` is 0 and `pad_oe` is 0.
- R2: With no override, `pad_oe[i]` is the inverse of direction bit i. Writing 0x04 to address 2 makes pins 1:0 and 4:3 drive (`pad_oe`=5'b11011) and leaves pin 2 as an input.
- R3: When `ovr_en[i]` is 1, `pad_oe[i]` equals `ovr_out[i]` (1 = force output, 0 = force input). The direction register read-back still returns the last written value.
- R4: `pad_out[i]` equals `ovr_data[i]` when `ovr_en[i]`, `ovr_out[i]` and `ovr_den[i]` are all 1. Otherwise it equals latch bit i.
- R5: In the direction and latch registers, bits 7:5 read as 0 and writes to those bits have no effect.
- R6: Writing address 0 stores data bits 7:5 as `pu_en[2:0]` (bit 5 drives `pu_en[0]`). Reading address 0 returns them in bits 7:5.
- R7: A write to address 0 or to address 1 loads data bits 4:0 into the latch. Writing 0 to either address clears the latch.
- R8: Reading address 0 returns `pad_in` in bits 4:0, delayed by two clock edges. Reading address 1 returns the latch.
- R9: Address 3 reads as 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, same cycle |
| pad_in | input | 5 | Raw pin input levels |
| pad_out | output | 5 | Pad drive value |
| pad_oe | output | 5 | Pad output enable, 1 = drive |
| ovr_en | input | 5 | Per-pin peripheral override request |
| ovr_out | input | 5 | Override direction, 1 = force output, 0 = force input |
| ovr_den | input | 5 | Override supplies drive value |
| ovr_data | input | 5 | Override drive value |
| pu_en | output | 3 | Weak pull-up enables for three other ports |

## Verification
Two functions meet in the same cycle. A software write to the direction register can arrive while a peripheral override holds the same pin, and a port-data write can clear the latch while an override is supplying the pad value. The bench sets the override pins, then writes the direction and latch registers. It checks that `pad_oe` and `pad_out` follow the override, and that the direction and latch read-back show exactly what software wrote. Port-data writes are also judged for their side effect on the pull-up bits, and synchronizer reads are sampled one edge early and on time to pin down the two-edge delay.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  typedef enum logic [1:0] {
    A_PORT = 2'd0,
    A_LAT  = 2'd1,
    A_DIR  = 2'd2,
    A_RSVD = 2'd3
  } gpio_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ovr_pkg::*;
#(
  parameter int NPIN = 5,
  parameter int NPU  = 3,
  parameter int DW   = NPIN + NPU
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      addr,
  input  logic            wr,
  input  logic [DW-1:0]   wdata,
  input  logic [NPIN-1:0] sync_in,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] lat_q,
  output logic [NPU-1:0]  pu_q,
  output logic [DW-1:0]   rdata
);
  localparam logic [NPU-1:0] NO_BITS = '0;

  gpio_addr_e sel;
  assign sel = gpio_addr_e'(addr);

  logic wr_port, wr_lat, wr_dir;
  assign wr_port = wr && (sel == A_PORT);
  assign wr_lat  = wr && (sel == A_LAT);
  assign wr_dir  = wr && (sel == A_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
      pu_q  <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata[NPIN-1:0];
      if (wr_port || wr_lat) lat_q <= wdata[NPIN-1:0];
      if (wr_port) pu_q <= wdata[DW-1:NPIN];
    end
  end

  always_comb begin
    unique case (sel)
      A_PORT:  rdata = {pu_q, sync_in};
      A_LAT:   rdata = {NO_BITS, lat_q};
      A_DIR:   rdata = {NO_BITS, dir_q};
      default: rdata = '0;
    endcase
  end

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == 2'd2) |=> $stable(dir_q)); // R3
  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (addr == 2'd0 || addr == 2'd1)) |=> $stable(lat_q)); // R7
  AST_PU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == 2'd0) |=> $stable(pu_q)); // R6
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int NPIN = 5
) (
  input  logic [NPIN-1:0] dir_q,
  input  logic [NPIN-1:0] lat_q,
  input  logic [NPIN-1:0] ovr_en,
  input  logic [NPIN-1:0] ovr_out,
  input  logic [NPIN-1:0] ovr_den,
  input  logic [NPIN-1:0] ovr_data,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic take_data;
    assign take_data  = ovr_en[i] & ovr_out[i] & ovr_den[i];
    assign pad_oe[i]  = ovr_en[i] ? ovr_out[i] : ~dir_q[i];
    assign pad_out[i] = take_data ? ovr_data[i] : lat_q[i];
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port #(
  parameter int NPIN        = 5,
  parameter int NPU         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic [NPIN+NPU-1:0]  bus_wdata,
  output logic [NPIN+NPU-1:0]  bus_rdata,
  input  logic [NPIN-1:0]      pad_in,
  output logic [NPIN-1:0]      pad_out,
  output logic [NPIN-1:0]      pad_oe,
  input  logic [NPIN-1:0]      ovr_en,
  input  logic [NPIN-1:0]      ovr_out,
  input  logic [NPIN-1:0]      ovr_den,
  input  logic [NPIN-1:0]      ovr_data,
  output logic [NPU-1:0]       pu_en
);
  localparam int DW = NPIN + NPU;

  logic [NPIN-1:0] sync_in, dir_q, lat_q;
  logic [NPU-1:0]  pu_q;

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_in)
  );

  gpio_regs #(.NPIN(NPIN), .NPU(NPU), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .sync_in(sync_in), .dir_q(dir_q),
    .lat_q(lat_q), .pu_q(pu_q), .rdata(bus_rdata)
  );

  gpio_pin_mux #(.NPIN(NPIN)) u_mux (
    .dir_q(dir_q), .lat_q(lat_q), .ovr_en(ovr_en), .ovr_out(ovr_out),
    .ovr_den(ovr_den), .ovr_data(ovr_data), .pad_oe(pad_oe),
    .pad_out(pad_out)
  );

  assign pu_en = pu_q;

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en == '0 && bus_addr == 2'd2) |-> (pad_oe == ~bus_rdata[NPIN-1:0])); // R2
  AST_OUT_FOLLOWS_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en == '0 && bus_addr == 2'd1) |-> (pad_out == bus_rdata[NPIN-1:0])); // R4
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != 2'd0) |-> (bus_rdata[DW-1:NPIN] == '0)); // R5
  AST_PU_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[DW-1:NPIN] == pu_en)); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == '0)); // R9
endmodule

// File: tb/gpio_ovr_port_tb.sv
module gpio_ovr_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [4:0] pad_in = 5'h00, pad_out, pad_oe;
  logic [4:0] ovr_en = '0, ovr_out = '0, ovr_den = '0, ovr_data = '0;
  logic [2:0] pu_en;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  gpio_ovr_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .ovr_en(ovr_en), .ovr_out(ovr_out),
    .ovr_den(ovr_den), .ovr_data(ovr_data), .pu_en(pu_en)
  );

  // fields: dir, lat, ovr_en, ovr_out, ovr_den, ovr_data, exp_oe, exp_out
  localparam logic [39:0] VECS [6] = '{
    {5'b00100, 5'b10101, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b11011, 5'b10101},
    {5'b11111, 5'b00000, 5'b00011, 5'b00011, 5'b00001, 5'b11111, 5'b00011, 5'b00001},
    {5'b00000, 5'b11111, 5'b11000, 5'b01000, 5'b11000, 5'b00000, 5'b01111, 5'b10111},
    {5'b01010, 5'b01100, 5'b10101, 5'b00100, 5'b00100, 5'b00000, 5'b00100, 5'b01000},
    {5'b10001, 5'b00011, 5'b00110, 5'b00110, 5'b00000, 5'b11111, 5'b01110, 5'b00011},
    {5'b11111, 5'b11010, 5'b11111, 5'b11111, 5'b11111, 5'b00101, 5'b11111, 5'b00101}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd2, r); chk("R1 dir", r, 8'h1F);
    rd(2'd1, r); chk("R1 lat", r, 8'h00);
    rd(2'd0, r); chk("R1 pu bits", {5'b0, r[7:5]}, 8'h00);
    chk("R1 pad_oe", {3'b0, pad_oe}, 8'h00);
    chk("R1 pu_en", {5'b0, pu_en}, 8'h00);

    // R2 R3 R4 vector walk: overrides set first, then software writes land under them
    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      ovr_en = VECS[v][29:25]; ovr_out = VECS[v][24:20];
      ovr_den = VECS[v][19:15]; ovr_data = VECS[v][14:10];
      wr(2'd2, {3'b000, VECS[v][39:35]});
      wr(2'd1, {3'b000, VECS[v][34:30]});
      chk("R2 R3 pad_oe", {3'b0, pad_oe}, {3'b0, VECS[v][9:5]});
      chk("R4 pad_out", {3'b0, pad_out}, {3'b0, VECS[v][4:0]});
      rd(2'd2, r); chk("R3 dir readback", r, {3'b0, VECS[v][39:35]});
      rd(2'd1, r); chk("R8 lat readback", r, {3'b0, VECS[v][34:30]});
    end
    @(negedge clk);
    ovr_en = '0; ovr_out = '0; ovr_den = '0; ovr_data = '0;

    // R5 upper bits of dir / latch
    wr(2'd2, 8'hFF); rd(2'd2, r); chk("R5 dir upper", r, 8'h1F);
    wr(2'd1, 8'hE3); rd(2'd1, r); chk("R5 lat upper", r, 8'h03);
    chk("R5 pu untouched", {5'b0, pu_en}, 8'h00);

    // R6 pull-up bits through port data
    wr(2'd0, 8'hA5);
    chk("R6 pu_en", {5'b0, pu_en}, 8'h05);
    rd(2'd0, r); chk("R6 port upper", {5'b0, r[7:5]}, 8'h05);
    rd(2'd1, r); chk("R7 port write to lat", r, 8'h05);

    // R7 clear via either address
    wr(2'd1, 8'h1F); wr(2'd0, 8'h00);
    rd(2'd1, r); chk("R7 clear via port", r, 8'h00);
    chk("R7 pu cleared", {5'b0, pu_en}, 8'h00);
    wr(2'd0, 8'h5F); wr(2'd1, 8'h00);
    rd(2'd1, r); chk("R7 clear via lat", r, 8'h00);
    chk("R7 pu kept", {5'b0, pu_en}, 8'h02);

    // R8 two-edge synchronizer delay
    @(negedge clk); pad_in = 5'h16;
    @(negedge clk); rd(2'd0, r); chk("R8 sync early", {3'b0, r[4:0]}, 8'h00);
    @(negedge clk); rd(2'd0, r); chk("R8 sync on time", {3'b0, r[4:0]}, 8'h16);

    // R9 unused address
    wr(2'd2, 8'h0A);
    wr(2'd3, 8'hFF);
    rd(2'd3, r); chk("R9 rsvd read", r, 8'h00);
    rd(2'd2, r); chk("R9 dir kept", r, 8'h0A);
    rd(2'd1, r); chk("R9 lat kept", r, 8'h00);
    chk("R9 pu kept", {5'b0, pu_en}, 8'h02);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule